// File: doc/BRIEF.md
# Shared-Bus Serial Peripheral Controller with Mode-Fault Detection

This block is an 8-bit serial peripheral interface controller for a bus on which more than one device may take the master role. Software reaches it through a small register port. It can load a byte to send, read the byte received last, choose clock polarity, phase and bit rate, and read a status word. As master, the controller produces the serial clock, shifts the outgoing byte onto the data-out line with the most significant bit first, samples the data-in line, and holds its single active-low slave-select output low for the length of the frame.

The serial clock and data-out lines each come as a level plus a separate drive enable. A pad ring can then build open-drain pins, and the controller lets go of the lines whenever it is not master. The controller also watches its own active-low select input through a two-flop synchronizer. If that input goes low while it is master, another master has claimed the bus. The controller then stops any frame in flight, drops its master enable so that it stops driving, and raises a sticky collision flag. While that flag is set, no new frame can start.

Register map (2-bit address): 0 = data (a write sends, a read returns the received byte); 1 = control (bit 0 master enable, bit 1 clock polarity, bit 2 phase); 2 = status (bit 0 busy, bit 1 done, bit 2 collision; writing 1 to bit 1 or bit 2 clears that flag); 3 = rate reload value N.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset, every register reads 0. Both drive enables are low, the serial clock is low and the select output is high.
- R2: With phase 0, bit 7 is on data-out before the first clock edge. The input is sampled on the first edge of each bit and data-out moves to the next bit on the second edge. Eight bits go out and come in, most significant first.
- R3: With phase 1, data-out moves to the next bit on the first edge of each bit (bit 7 is already presented from the start) and the input is sampled on the second edge.
- R4: When no frame is running, the serial clock rests at the polarity bit, one cycle after that bit is written. A frame has 16 clock edges. Each level lasts N system cycles (a reload of 0 acts as 1), and the first edge comes N cycles after the start.
- R5: A write to address 0 while master, idle and free of collision starts a frame. From the next cycle, busy is 1 and the select output is low for 16·N cycles. On the clock edge that makes the last serial edge, busy drops, select goes high, done is set and the received byte becomes readable at address 0.
- R6: A write to address 0 is ignored while busy, while not master, or while the collision flag is set. No frame starts and the frame in flight is unchanged.
- R7: Writes to control (address 1) and reload (address 3) while busy are ignored, and the registers keep their values.
- R8: Both drive enables equal the master-enable bit. While not master, the controller is never busy.
- R9: If the master-enable bit is 1 and the synchronized select input is low, then on the next cycle the collision flag is 1 and master enable is 0. Any frame is aborted without setting done, select goes high and the serial clock returns to its idle level. The input passes through two flops first.
- R10: Collision stays set until a 1 is written to status bit 2. Done stays set until a 1 is written to status bit 1 or a new frame starts. When a set and a clear fall in the same cycle, the set wins.
- R11: A collision in the same cycle as the final serial edge aborts the frame. Done stays 0 and the data register keeps its previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data for rd_addr |
| sck_o | output | 1 | Serial clock level |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_o | output | 1 | Serial data-out level |
| mosi_oe | output | 1 | Serial data-out drive enable |
| miso_i | input | 1 | Serial data-in |
| ss_in_n | input | 1 | Own active-low select input, watched for another master |
| sel_n_o | output | 1 | Active-low slave-select output |

## Verification
There are two collision cases to provoke. The first is a collision that lands on the very cycle the final serial edge would finish a frame. The bench times the select input to fall exactly three cycles before that edge, so the synchronized fault meets it there. The result must be no done flag and an unchanged data register. The second is a collision that lands on the same cycle as a software write clearing the collision flag. It is provoked by enabling master while the select input is held low and then writing the clear in the cycle right after, and the flag must stay set. A behavioural model in the bench tracks every pin and the register read port on every clock. The named checks that follow each case confirm the flags.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_RATE = 2'd3;

  localparam int CTL_MASTER = 0;
  localparam int CTL_CPOL   = 1;
  localparam int CTL_CPHA   = 2;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_COL  = 2;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic master;
  } ctrl_t;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_mf_baud.sv
module spi_mf_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (reload == '0) ? '0 : reload - DIV_W'(1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_mf_engine.sv
module spi_mf_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         abort,
  input  logic         tick,
  input  logic [W-1:0] tx_data,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         miso,
  output logic         busy,
  output logic         sck,
  output logic         sel_n,
  output logic         mosi,
  output logic         fin,
  output logic [W-1:0] rx_data
);
  localparam int EDGES = 2 * W;
  localparam int ECW   = $clog2(EDGES);

  logic [W-1:0]   tx_sr;
  logic [W-1:0]   rx_sr;
  logic [ECW-1:0] edge_cnt;
  logic           lead;
  logic           last;
  logic           smp;
  logic           sh;
  logic           step;

  assign lead = ~edge_cnt[0];
  assign last = (edge_cnt == ECW'(EDGES - 1));
  assign smp  = cpha ? ~lead : lead;
  assign sh   = cpha ? (lead && edge_cnt != '0) : (~lead && !last);
  assign step = busy && tick && !abort;
  assign fin  = step && last;
  assign mosi = busy ? tx_sr[W-1] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sel_n    <= 1'b1;
      sck      <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_data  <= '0;
      edge_cnt <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      sel_n <= 1'b1;
      sck   <= cpol;
    end else if (busy) begin
      if (tick) begin
        sck      <= ~sck;
        edge_cnt <= edge_cnt + ECW'(1);
        if (smp) rx_sr <= {rx_sr[W-2:0], miso};
        if (sh)  tx_sr <= {tx_sr[W-2:0], 1'b0};
        if (last) begin
          busy    <= 1'b0;
          sel_n   <= 1'b1;
          rx_data <= smp ? {rx_sr[W-2:0], miso} : rx_sr;
        end
      end
    end else begin
      sck <= cpol;
      if (start) begin
        busy     <= 1'b1;
        sel_n    <= 1'b0;
        tx_sr    <= tx_data;
        edge_cnt <= '0;
      end
    end
  end

  // R5: a frame begins only from an accepted start
  assert_busy_from_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R4: every rate tick inside a frame toggles the serial clock
  assert_tick_toggles_sck_R4: assert property (@(posedge clk) disable iff (rst)
    step |=> sck != $past(sck));

  // R4: outside a frame the clock rests at the polarity level
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> sck == $past(cpol));
endmodule

// File: rtl/spi_mf_regs.sv
module spi_mf_regs
  import spi_mf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              busy,
  input  logic              fin,
  input  logic              fault,
  input  logic [DATA_W-1:0] rx_data,
  output ctrl_t             ctrl,
  output logic [DIV_W-1:0]  reload,
  output logic              start
);
  logic done;
  logic col;
  logic wr_ctrl;
  logic wr_rate;
  logic wr_stat;

  assign wr_ctrl = wr_en && wr_addr == ADDR_CTRL && !busy;
  assign wr_rate = wr_en && wr_addr == ADDR_RATE && !busy;
  assign wr_stat = wr_en && wr_addr == ADDR_STAT;
  assign start   = wr_en && wr_addr == ADDR_DATA && ctrl.master && !col
                   && !busy && !fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
      done   <= 1'b0;
      col    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl.master <= wr_data[CTL_MASTER];
        ctrl.cpol   <= wr_data[CTL_CPOL];
        ctrl.cpha   <= wr_data[CTL_CPHA];
      end
      if (fault) ctrl.master <= 1'b0;
      if (wr_rate) reload <= DIV_W'(wr_data);
      if (fin)                           done <= 1'b1;
      else if (start)                    done <= 1'b0;
      else if (wr_stat && wr_data[ST_DONE]) done <= 1'b0;
      if (fault)                         col <= 1'b1;
      else if (wr_stat && wr_data[ST_COL])  col <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_DATA: rd_data = rx_data;
      ADDR_CTRL: begin
        rd_data[CTL_MASTER] = ctrl.master;
        rd_data[CTL_CPOL]   = ctrl.cpol;
        rd_data[CTL_CPHA]   = ctrl.cpha;
      end
      ADDR_STAT: begin
        rd_data[ST_BUSY] = busy;
        rd_data[ST_DONE] = done;
        rd_data[ST_COL]  = col;
      end
      default: rd_data = DATA_W'(reload);
    endcase
  end

  // R9: a detected fault flags a collision and drops master
  assert_fault_sets_col_R9: assert property (@(posedge clk) disable iff (rst)
    fault |=> (col && !ctrl.master));

  // R10: collision holds unless software clears it
  assert_col_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (col && !(wr_stat && wr_data[ST_COL])) |=> col);

  // R11: an aborted frame never raises done
  assert_abort_no_done_R11: assert property (@(posedge clk) disable iff (rst)
    (fault && !done) |=> !done);
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  input  logic              ss_in_n,
  output logic              sel_n_o
);
  ctrl_t             ctrl;
  logic [DIV_W-1:0]  reload;
  logic [DATA_W-1:0] rx_data;
  logic              start;
  logic              busy;
  logic              fin;
  logic              tick;
  logic              ss_sync;
  logic              fault;

  spi_mf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ss_in_n), .q(ss_sync)
  );

  assign fault = ctrl.master && !ss_sync;

  spi_mf_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .fin(fin), .fault(fault), .rx_data(rx_data),
    .ctrl(ctrl), .reload(reload), .start(start)
  );

  spi_mf_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .reload(reload), .tick(tick)
  );

  spi_mf_engine #(.W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .start(start), .abort(fault), .tick(tick),
    .tx_data(wr_data), .cpol(ctrl.cpol), .cpha(ctrl.cpha), .miso(miso_i),
    .busy(busy), .sck(sck_o), .sel_n(sel_n_o), .mosi(mosi_o),
    .fin(fin), .rx_data(rx_data)
  );

  assign sck_oe  = ctrl.master;
  assign mosi_oe = ctrl.master;

  // R8: a controller that is not master never runs a frame
  assert_idle_when_not_master_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.master |-> !busy);
endmodule

// File: tb/spi_mf_ctrl_test.sv
`timescale 1ns/1ps
module spi_mf_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd2;
  logic [7:0] rd_data;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, sel_n_o;
  logic       miso_i = 1'b0;
  logic       ss_in_n = 1'b1;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  spi_mf_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .ss_in_n(ss_in_n),
    .sel_n_o(sel_n_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic m_master, m_cpol, m_cpha, m_col, m_done, m_busy, m_seln, m_sck;
  logic m_s1, m_s2;
  logic [7:0] m_div, m_tx, m_rx, m_rxbyte;
  int m_t, m_n, m_bit;

  always @(posedge clk) begin
    logic o_busy, o_cpol, flt, go, fin, lead;
    int e;
    if (rst) begin
      m_master = 0; m_cpol = 0; m_cpha = 0; m_col = 0; m_done = 0;
      m_busy = 0; m_seln = 1; m_sck = 0; m_s1 = 1; m_s2 = 1;
      m_div = 0; m_tx = 0; m_rx = 0; m_rxbyte = 0; m_t = 0; m_n = 1; m_bit = 0;
    end else begin
      o_busy = m_busy; o_cpol = m_cpol;
      flt = m_master && !m_s2;
      m_s2 = m_s1; m_s1 = ss_in_n;
      go = wr_en && wr_addr == 2'd0 && m_master && !m_col && !m_busy && !flt;
      fin = 0;
      if (flt) begin
        m_busy = 0; m_seln = 1; m_sck = o_cpol;
      end else if (m_busy) begin
        m_t++;
        if (m_t % m_n == 0) begin
          e = m_t / m_n;
          m_sck = !m_sck;
          lead = (e % 2 == 1);
          if (m_cpha ? !lead : lead) m_rx = {m_rx[6:0], miso_i};
          if (m_cpha ? (lead && e > 1) : (!lead && e < 16)) m_bit++;
          if (e == 16) begin
            m_busy = 0; m_seln = 1; m_rxbyte = m_rx; fin = 1;
          end
        end
      end else begin
        m_sck = o_cpol;
        if (go) begin
          m_busy = 1; m_seln = 0; m_tx = wr_data; m_bit = 0; m_t = 0;
          m_n = (m_div == 0) ? 1 : int'(m_div);
        end
      end
      if (wr_en && wr_addr == 2'd1 && !o_busy) begin
        m_master = wr_data[0]; m_cpol = wr_data[1]; m_cpha = wr_data[2];
      end
      if (flt) m_master = 0;
      if (wr_en && wr_addr == 2'd3 && !o_busy) m_div = wr_data;
      if (fin) m_done = 1;
      else if (go) m_done = 0;
      else if (wr_en && wr_addr == 2'd2 && wr_data[1]) m_done = 0;
      if (flt) m_col = 1;
      else if (wr_en && wr_addr == 2'd2 && wr_data[2]) m_col = 0;
    end
  end

  function automatic int model_rd(input logic [1:0] a);
    case (a)
      2'd0: return int'(m_rxbyte);
      2'd1: return int'({m_cpha, m_cpol, m_master});
      2'd2: return int'({m_col, m_done, m_busy});
      default: return int'(m_div);
    endcase
  endfunction

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      chk("R4 sck", int'(sck_o), int'(m_sck));
      chk("R8 sck_oe", int'(sck_oe), int'(m_master));
      chk("R8 mosi_oe", int'(mosi_oe), int'(m_master));
      chk(m_cpha ? "R3 mosi" : "R2 mosi", int'(mosi_o),
          m_busy ? int'(m_tx[7 - m_bit]) : 1);
      chk("R5 sel_n", int'(sel_n_o), int'(m_seln));
      chk("R10 rd_data", int'(rd_data), model_rd(rd_addr));
    end
  end

  // slave-side data pattern, changes away from the edge
  logic [7:0] lfsr = 8'hB7;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    miso_i <= lfsr[7];
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1 v = int'(rd_data);
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd2, v);
      if (v[0] == 1'b0) return;
    end
    chk("R5 frame end", 1, 0);
  endtask

  int v, prev;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(2'd2, v); chk("R1 status", v, 0);
    rd(2'd1, v); chk("R1 ctrl", v, 0);
    rd(2'd0, v); chk("R1 data", v, 0);
    chk("R1 sel_n", int'(sel_n_o), 1);
    chk("R1 oe", int'(sck_oe | mosi_oe), 0);
    chk("R1 sck", int'(sck_o), 0);

    // R6 not master: write ignored
    wr(2'd0, 8'h55);
    rd(2'd2, v); chk("R6 not master", v, 0);

    // R2 phase 0, polarity 0
    wr(2'd3, 8'd2); wr(2'd1, 8'h01); wr(2'd0, 8'hA5);
    wait_idle();
    rd(2'd2, v); chk("R5 done", v, 2);
    rd(2'd0, v); chk("R2 rx byte", v, int'(m_rxbyte));
    wr(2'd2, 8'h02);
    rd(2'd2, v); chk("R10 done clear", v, 0);

    // R3 phase 1, polarity 1, plus ignored writes while busy
    wr(2'd3, 8'd3); wr(2'd1, 8'h07);
    repeat (2) @(negedge clk);
    chk("R4 idle high", int'(sck_o), 1);
    wr(2'd0, 8'h3C);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h01);
    wr(2'd3, 8'd9);
    wait_idle();
    rd(2'd1, v); chk("R7 ctrl kept", v, 7);
    rd(2'd3, v); chk("R7 rate kept", v, 3);
    rd(2'd0, v); chk("R3 rx byte", v, int'(m_rxbyte));

    // R4 reload 0 acts as 1
    wr(2'd3, 8'd0); wr(2'd1, 8'h05); wr(2'd0, 8'hC3);
    wait_idle();
    rd(2'd2, v); chk("R4 fast frame done", v, 2);

    // R9 collision mid-frame
    wr(2'd3, 8'd4); wr(2'd1, 8'h01); wr(2'd0, 8'h96);
    repeat (20) @(negedge clk);
    ss_in_n = 0;
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R9 status", v, 4);
    rd(2'd1, v); chk("R9 master dropped", v, 0);
    chk("R9 sel_n", int'(sel_n_o), 1);

    // R10 set wins over clear in the same cycle
    @(negedge clk); wr_en = 1; wr_addr = 2'd1; wr_data = 8'h01;
    @(negedge clk); wr_addr = 2'd2; wr_data = 8'h04;
    @(negedge clk); wr_en = 0;
    rd(2'd2, v); chk("R10 set wins", v, 4);
    ss_in_n = 1;
    repeat (4) @(negedge clk);

    // R6 collision blocks a start
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h11);
    rd(2'd2, v); chk("R6 col blocks", v, 4);
    chk("R6 sel_n", int'(sel_n_o), 1);
    wr(2'd2, 8'h04);
    rd(2'd2, v); chk("R10 col clear", v, 0);

    // R11 collision on the final edge
    wr(2'd3, 8'd1);
    rd(2'd0, prev);
    @(negedge clk); wr_en = 1; wr_addr = 2'd0; wr_data = 8'h5A;
    @(negedge clk); wr_en = 0;
    repeat (13) @(negedge clk);
    ss_in_n = 0;
    repeat (6) @(negedge clk);
    ss_in_n = 1;
    rd(2'd2, v); chk("R11 no done", v, 4);
    rd(2'd0, v); chk("R11 data kept", v, prev);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule